// File: doc/BRIEF.md
# Assertion Failure Scan and Recovery Dispatcher

This block sits between a bank of hardware assertion checkers and a processor core. When the checkers raise a trigger, the dispatcher captures their one-bit failure flags in parallel into an internal scan chain. It then shifts that chain out one position per clock and counts the positions as it goes. The first position that holds a 1 becomes the error number. The error number addresses a small programmable table, and the table selects one recovery action toward the core. The four actions are a held halt request, a hardware reset pulse, a software interrupt pulse, and a start pulse for a dedicated exception handler.

The table is loaded through a simple write port: an enable, an index and a 2-bit action code. Entries that have never been written select the software interrupt. If a trigger arrives while a scan is running, it is captured and served once the current scan ends. A scan that finds no set flag issues no action and raises a sticky spurious indication. Only one trigger can wait at a time; a further trigger that arrives while one is already waiting is dropped.

Top module: `assert_scan_dispatch`

## Requirements
- R1: After reset, every action output, `busy_o` and `spurious_o` are low, and `err_num_o` is 0. The table starts with every entry unmapped.
- R2: A trigger accepted on a rising edge captures `flags_i` on that edge. `busy_o` is high from that edge until the action edge (R3), or until the end-of-scan edge (R10). Changes on `flags_i` after the capture edge have no effect on the scan.
- R3: The chain is scanned from flag bit 0 upward, one position per clock. If the lowest set captured bit is k, the action appears on the (k+2)-th rising edge after the capture edge, and `busy_o` falls on that same edge unless another scan follows.
- R4: `err_num_o` takes the value k on the edge where the set bit is found. It holds that value until a later scan finds a set bit.
- R5: When several captured flags are set, the lowest index wins. Higher set bits in the same scan are ignored.
- R6: Action codes are 0 = halt, 1 = hardware reset, 2 = software interrupt, 3 = exception handler start. Writing `tbl_act_i` at `tbl_idx_i` with `tbl_we_i` high maps that entry, and an unmapped entry selects code 2. The table is read on the cycle the action is issued.
- R7: `hw_reset_o`, `sw_irq_o` and `exc_start_o` are single-cycle pulses. At most one of them is high in any cycle.
- R8: `halt_o` is a level. It stays high until `halt_clr_i` is sampled high. If a halt action and a clear land on the same edge, the halt is set.
- R9: A trigger sampled while a scan is running is held and scanned after the current scan ends. This includes a trigger on the cycle the action is issued. That next scan starts on the end edge with no idle cycle in between.
- R10: If all captured flags are 0, `busy_o` falls on the LEN-th edge after capture and no action is issued. `spurious_o` is set on that edge and stays set until a later scan issues an action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Error-detected trigger from the checkers |
| flags_i | input | LEN | Assertion failure flags, captured on an accepted trigger |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | IDX_W | Table entry index |
| tbl_act_i | input | 2 | Action code written to the entry |
| halt_clr_i | input | 1 | Clears the held halt request |
| halt_o | output | 1 | Halt request to the core (level) |
| hw_reset_o | output | 1 | Hardware reset pulse |
| sw_irq_o | output | 1 | Software interrupt request pulse |
| exc_start_o | output | 1 | Exception handler start pulse |
| busy_o | output | 1 | Scan or issue in progress |
| spurious_o | output | 1 | Last scan ended with no flag set |
| err_num_o | output | IDX_W | Position of the failing assertion |

## Verification
The critical coincidence is a new trigger landing on the same edge where the running scan issues its action. The end-of-scan logic must both fire the action and reload the chain, without losing the trigger or the pulse. The bench provokes this by driving the second trigger on the issue cycle of a first scan, and also on the first cycle of a scan. It judges the result from the recorded per-cycle outputs: the first action must appear at its predicted edge while `busy_o` stays high, and the second action must appear exactly at the edge predicted from its own flag position. A halt set coinciding with a halt clear is exercised the same way.

// File: rtl/asd_pkg.sv
package asd_pkg;

  // Recovery action codes; values are visible at the table write port
  typedef enum logic [1:0] {
    ACT_HALT  = 2'd0,
    ACT_RESET = 2'd1,
    ACT_SWI   = 2'd2,
    ACT_EXC   = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_ISSUE = 2'd2
  } state_e;

endpackage

// File: rtl/asd_chain.sv
// Internal scan chain: parallel load, serial shift toward bit 0, position counter.
module asd_chain #(
  parameter int LEN = 16,
  localparam int IW = $clog2(LEN)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [LEN-1:0] load_data_i,
  input  logic           shift_i,
  output logic           head_o,
  output logic [IW-1:0]  pos_o,
  output logic           last_o
);

  logic [LEN-1:0] sr_q, sr_d;
  logic [IW-1:0]  cnt_q, cnt_d;
  logic           en;

  assign en = load_i | shift_i;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (load_i) begin
      sr_d  = load_data_i;
      cnt_d = '0;
    end else if (shift_i) begin
      sr_d  = {1'b0, sr_q[LEN-1:1]};
      cnt_d = cnt_q + IW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o = sr_q[0];
  assign pos_o  = cnt_q;
  assign last_o = (cnt_q == IW'(LEN - 1));

endmodule

// File: rtl/asd_prio_tbl.sv
// Error-number to action table; unmapped entries resolve to the software interrupt.
module asd_prio_tbl
  import asd_pkg::*;
#(
  parameter int LEN = 16,
  localparam int IW = $clog2(LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [1:0]    wact_i,
  input  logic [IW-1:0] ridx_i,
  output act_e          ract_o
);

  act_e       act_q [LEN];
  logic [LEN-1:0] map_q;

  for (genvar i = 0; i < LEN; i++) begin : g_ent
    logic sel;
    assign sel = we_i && (widx_i == IW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[i] <= ACT_SWI;
        map_q[i] <= 1'b0;
      end else if (sel) begin
        act_q[i] <= act_e'(wact_i);
        map_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    ract_o = ACT_SWI;
    if (map_q[ridx_i]) ract_o = act_q[ridx_i];
  end

endmodule

// File: rtl/asd_issue.sv
// Action output stage: registered pulses plus a held halt level.
module asd_issue
  import asd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  act_e act_i,
  input  logic halt_clr_i,
  output logic halt_o,
  output logic rst_o,
  output logic swi_o,
  output logic exc_o
);

  logic halt_q, halt_d;
  logic rst_q, rst_d, swi_q, swi_d, exc_q, exc_d;
  logic halt_en;

  always_comb begin
    rst_d  = fire_i && (act_i == ACT_RESET);
    swi_d  = fire_i && (act_i == ACT_SWI);
    exc_d  = fire_i && (act_i == ACT_EXC);
    halt_d = halt_q;
    if (fire_i && (act_i == ACT_HALT)) halt_d = 1'b1;
    else if (halt_clr_i)               halt_d = 1'b0;
  end

  assign halt_en = fire_i | halt_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      rst_q  <= 1'b0;
      swi_q  <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      rst_q <= rst_d;
      swi_q <= swi_d;
      exc_q <= exc_d;
      if (halt_en) halt_q <= halt_d;
    end
  end

  assign halt_o = halt_q;
  assign rst_o  = rst_q;
  assign swi_o  = swi_q;
  assign exc_o  = exc_q;

endmodule

// File: rtl/assert_scan_dispatch.sv
module assert_scan_dispatch
  import asd_pkg::*;
#(
  parameter int LEN = 16,
  localparam int IDX_W = $clog2(LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [LEN-1:0]   flags_i,
  input  logic             tbl_we_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic [1:0]       tbl_act_i,
  input  logic             halt_clr_i,
  output logic             halt_o,
  output logic             hw_reset_o,
  output logic             sw_irq_o,
  output logic             exc_start_o,
  output logic             busy_o,
  output logic             spurious_o,
  output logic [IDX_W-1:0] err_num_o
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  state_e           st_q, st_d;
  logic             pend_q, pend_d;
  logic [LEN-1:0]   pflg_q, pflg_d;
  logic [IDX_W-1:0] err_q;
  logic             spur_q;

  logic             ld, shf, fire, found, miss, finish;
  logic [LEN-1:0]   ld_data;
  logic             head, last;
  logic [IDX_W-1:0] pos;
  act_e             sel_act;

  asd_chain #(.LEN(LEN)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (ld),
    .load_data_i(ld_data),
    .shift_i    (shf),
    .head_o     (head),
    .pos_o      (pos),
    .last_o     (last)
  );

  asd_prio_tbl #(.LEN(LEN)) u_tbl (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .we_i  (tbl_we_i),
    .widx_i(tbl_idx_i),
    .wact_i(tbl_act_i),
    .ridx_i(err_q),
    .ract_o(sel_act)
  );

  asd_issue u_issue (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .fire_i    (fire),
    .act_i     (sel_act),
    .halt_clr_i(halt_clr_i),
    .halt_o    (halt_o),
    .rst_o     (hw_reset_o),
    .swi_o     (sw_irq_o),
    .exc_o     (exc_start_o)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    pflg_d  = pflg_q;
    ld      = 1'b0;
    ld_data = flags_i;
    shf     = 1'b0;
    fire    = 1'b0;
    found   = 1'b0;
    miss    = 1'b0;
    finish  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          ld   = 1'b1;
          st_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (head) begin
          found = 1'b1;
          st_d  = ST_ISSUE;
        end else if (last) begin
          miss   = 1'b1;
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          shf = 1'b1;
        end
      end
      ST_ISSUE: begin
        fire   = 1'b1;
        finish = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (finish) begin
      if (pend_q) begin
        ld      = 1'b1;
        ld_data = pflg_q;
        st_d    = ST_SCAN;
        pend_d  = trig_i;
        if (trig_i) pflg_d = flags_i;
      end else if (trig_i) begin
        ld   = 1'b1;
        st_d = ST_SCAN;
      end
    end else if ((st_q != ST_IDLE) && trig_i && !pend_q) begin
      pend_d = 1'b1;
      pflg_d = flags_i;
    end
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      pflg_q <= '0;
      err_q  <= '0;
      spur_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      pflg_q <= pflg_d;
      if (found)     err_q  <= pos;
      if (miss)      spur_q <= 1'b1;
      else if (fire) spur_q <= 1'b0;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign spurious_o = spur_q;
  assign err_num_o  = err_q;

endmodule

// File: rtl/asd_chk.sv
module asd_chk #(
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          trig_i,
  input logic          halt_clr_i,
  input logic          halt_o,
  input logic          hw_reset_o,
  input logic          sw_irq_o,
  input logic          exc_start_o,
  input logic          busy_o,
  input logic          spurious_o,
  input logic [IW-1:0] err_num_o
);

  // R2
  trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    trig_i |=> busy_o);

  // R4
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |=> $stable(err_num_o));

  // R7
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({hw_reset_o, sw_irq_o, exc_start_o}));

  // R7
  rst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    hw_reset_o |=> !hw_reset_o);

  // R7
  swi_width_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sw_irq_o |=> !sw_irq_o);

  // R7
  exc_width_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    exc_start_o |=> !exc_start_o);

  // R3
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hw_reset_o || sw_irq_o || exc_start_o || $rose(halt_o)) |-> $past(busy_o));

  // R8
  halt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (halt_o && !halt_clr_i) |=> halt_o);

  // R10
  spur_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(spurious_o) |-> ($past(busy_o) && !hw_reset_o && !sw_irq_o && !exc_start_o));

endmodule

bind assert_scan_dispatch asd_chk #(.IW(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .trig_i     (trig_i),
  .halt_clr_i (halt_clr_i),
  .halt_o     (halt_o),
  .hw_reset_o (hw_reset_o),
  .sw_irq_o   (sw_irq_o),
  .exc_start_o(exc_start_o),
  .busy_o     (busy_o),
  .spurious_o (spurious_o),
  .err_num_o  (err_num_o)
);

// File: tb/sim_assert_scan_dispatch.sv
`timescale 1ns/1ps
module sim_assert_scan_dispatch;

  localparam int LEN = 16;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trig_i, tbl_we_i, halt_clr_i;
  logic [LEN-1:0] flags_i;
  logic [IW-1:0] tbl_idx_i;
  logic [1:0]    tbl_act_i;
  logic          halt_o, hw_reset_o, sw_irq_o, exc_start_o, busy_o, spurious_o;
  logic [IW-1:0] err_num_o;

  always #5 clk = ~clk;

  assert_scan_dispatch #(.LEN(LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig_i), .flags_i(flags_i),
    .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_act_i(tbl_act_i),
    .halt_clr_i(halt_clr_i), .halt_o(halt_o), .hw_reset_o(hw_reset_o),
    .sw_irq_o(sw_irq_o), .exc_start_o(exc_start_o), .busy_o(busy_o),
    .spurious_o(spurious_o), .err_num_o(err_num_o)
  );

  int errs = 0;
  int checks = 0;
  logic [1:0] m_act [LEN];
  bit         m_map [LEN];
  bit         m_halt = 1'b0;
  logic [3:0] rec_p [12];
  logic       rec_b [12];
  logic [IW-1:0] rec_e [12];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int first_one(input logic [LEN-1:0] f);
    for (int i = 0; i < LEN; i++) if (f[i]) return i;
    return -1;
  endfunction

  function automatic int exp_act(input int k);
    return m_map[k] ? int'(m_act[k]) : 2;
  endfunction

  // {reset, swi, exc} expected for an action code
  function automatic logic [2:0] pulse_vec(input int a);
    case (a)
      1: return 3'b100;
      2: return 3'b010;
      3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic tbl_write(input int idx, input int a);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_idx_i = IW'(idx); tbl_act_i = 2'(a);
    @(negedge clk);
    tbl_we_i = 1'b0;
    m_map[idx] = 1'b1; m_act[idx] = 2'(a);
  endtask

  task automatic clear_halt();
    @(negedge clk); halt_clr_i = 1'b1;
    @(negedge clk); halt_clr_i = 1'b0;
    chk(!halt_o, "R8 clear", halt_o, 0);
    m_halt = 1'b0;
  endtask

  task automatic run_one(input logic [LEN-1:0] f);
    int k, a;
    bit ok_busy, ok_quiet;
    string tag;
    k = first_one(f);
    ok_busy = 1'b1; ok_quiet = 1'b1;
    @(negedge clk); flags_i = f; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0; flags_i = ~f;   // R2: later flag changes ignored
    if (k < 0) begin
      for (int n = 0; n <= LEN; n++) begin
        if (n < LEN && !busy_o) ok_busy = 1'b0;
        if (hw_reset_o || sw_irq_o || exc_start_o || (halt_o != m_halt)) ok_quiet = 1'b0;
        if (n == LEN) begin
          chk(!busy_o, "R10 busy drop", busy_o, 0);
          chk(spurious_o, "R10 spurious set", spurious_o, 1);
        end else @(negedge clk);
      end
      chk(ok_busy, "R2 busy during scan", 0, 1);
      chk(ok_quiet, "R10 no action", 0, 1);
    end else begin
      a = exp_act(k);
      tag = ($countones(f) > 1) ? "R5" : "R4";
      for (int n = 0; n <= k + 3; n++) begin
        if (n < k + 2) begin
          if (!busy_o) ok_busy = 1'b0;
          if (hw_reset_o || sw_irq_o || exc_start_o || (halt_o != m_halt)) ok_quiet = 1'b0;
        end
        if (n == k + 2) begin
          chk(!busy_o, "R3 busy falls at action", busy_o, 0);
          chk({hw_reset_o, sw_irq_o, exc_start_o} == pulse_vec(a), "R6 action",
              int'({hw_reset_o, sw_irq_o, exc_start_o}), int'(pulse_vec(a)));
          chk(halt_o == (m_halt | (a == 0)), "R8 halt level", halt_o, int'(m_halt | (a == 0)));
          chk(err_num_o == IW'(k), {tag, " err number"}, err_num_o, k);
          chk(!spurious_o, "R10 spurious cleared", spurious_o, 0);
        end
        if (n == k + 3) begin
          chk({hw_reset_o, sw_irq_o, exc_start_o} == 3'b000, "R7 single cycle",
              int'({hw_reset_o, sw_irq_o, exc_start_o}), 0);
          chk(err_num_o == IW'(k), "R4 err held", err_num_o, k);
        end
        if (n < k + 3) @(negedge clk);
      end
      chk(ok_busy, "R2 busy until action", 0, 1);
      chk(ok_quiet, "R3 no early action", 0, 1);
      if (a == 0) m_halt = 1'b1;
    end
  endtask

  // Scan fa; drive a one-cycle trigger with fb when the sample index equals inj
  task automatic rec_run(input logic [LEN-1:0] fa, input logic [LEN-1:0] fb, input int inj);
    @(negedge clk); flags_i = fa; trig_i = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 12; n++) begin
      rec_p[n] = {halt_o, hw_reset_o, sw_irq_o, exc_start_o};
      rec_b[n] = busy_o;
      rec_e[n] = err_num_o;
      trig_i = (n == inj);
      if (n == inj) flags_i = fb;
      @(negedge clk);
    end
  endtask

  initial begin
    #(10 * 100000);
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [LEN-1:0] f;
    int seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < LEN; i++) begin m_map[i] = 1'b0; m_act[i] = 2'd2; end
    rst_n = 1'b0; trig_i = 1'b0; flags_i = '0; tbl_we_i = 1'b0;
    tbl_idx_i = '0; tbl_act_i = '0; halt_clr_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({halt_o, hw_reset_o, sw_irq_o, exc_start_o} == 4'b0, "R1 actions",
        int'({halt_o, hw_reset_o, sw_irq_o, exc_start_o}), 0);
    chk(!busy_o && !spurious_o, "R1 busy/spurious", int'({busy_o, spurious_o}), 0);
    chk(err_num_o == '0, "R1 err number", err_num_o, 0);

    // R6 unmapped entry selects software interrupt
    run_one(16'h0020);
    tbl_write(3, 1);
    tbl_write(0, 3);
    tbl_write(9, 0);
    run_one(16'h0008);
    run_one(16'h0001);
    run_one(16'h8208);          // R5 lowest set bit wins
    run_one(16'h0000);          // R10
    run_one(16'h0001);          // R10 cleared by action
    run_one(16'h8000);          // R3 last chain position
    run_one(16'h0200);          // R8 halt set
    run_one(16'h0008);          // R8 halt held across other action
    clear_halt();

    // R8 clear and halt on the same edge: halt wins
    tbl_write(1, 0);
    @(negedge clk); flags_i = 16'h0002; trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
    @(negedge clk);
    @(negedge clk); halt_clr_i = 1'b1;
    @(negedge clk); halt_clr_i = 1'b0;
    chk(halt_o, "R8 set beats clear", halt_o, 1);
    @(negedge clk);
    chk(halt_o, "R8 held after coincidence", halt_o, 1);
    m_halt = 1'b1;
    clear_halt();

    // R9 trigger during the first scan cycle
    rec_run(16'h0008, 16'h0001, 0);
    chk(rec_p[5] == 4'b0100 && rec_e[5] == 4'd3, "R9 first action",
        int'(rec_p[5]), 4);
    chk(rec_b[5] && rec_b[6], "R9 busy between scans", int'({rec_b[5], rec_b[6]}), 3);
    chk(rec_p[7] == 4'b0001 && rec_e[7] == 4'd0 && !rec_b[7], "R9 pending action",
        int'(rec_p[7]), 1);

    // R9 trigger on the issue cycle
    rec_run(16'h0004, 16'h0008, 3);
    chk(rec_p[4] == 4'b0010 && rec_b[4], "R9 issue-cycle first action",
        int'({rec_p[4], rec_b[4]}), 5);
    chk(rec_p[9] == 4'b0100 && rec_e[9] == 4'd3 && !rec_b[9], "R9 issue-cycle second action",
        int'(rec_p[9]), 4);
    chk(rec_p[8] == 4'b0000 && rec_b[8], "R9 second not early", int'(rec_p[8]), 0);

    // Constrained random
    for (int it = 0; it < 60; it++) begin
      if (($urandom % 3) == 0) tbl_write(int'($urandom % LEN), int'($urandom % 4));
      case ($urandom % 4)
        0: f = '0;
        1: f = LEN'(1) << ($urandom % LEN);
        default: f = LEN'($urandom);
      endcase
      run_one(f);
      if (m_halt && (($urandom % 2) == 0)) clear_halt();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule